// File: doc/BRIEF.md
# Access Violation Flag Capture Unit

This block collects bus-access-protection violations reported by the detection logic elsewhere in the chip. The violations fall into two groups. The non-master group has ten sources and the master group has four. Each source has a sticky flag and an interrupt enable bit. Each source also has a 32-bit register that records the address of the access that caused the violation. Each group drives one level interrupt, which is the OR of its enabled flags.

Software reaches every register through a simple register bus. The bus address counts 16-bit words, and each register is 32 bits wide at an even word address. Software cannot write the flags directly. It raises a flag through a write-1-to-set alias and lowers it through a write-1-to-clear alias. The set alias, the clear alias and the enable register respond only while the protection-unlock input is high.

The master write source from the host interface has two hardware lanes. Both lanes feed the same flag, and each lane has its own capture register.

Top module: `avf_capture_unit`

## Requirements
- R1: After reset, every flag, enable bit and capture register reads 0, and both interrupt outputs are low.
- R2: A violation pulse on a lane sets its flag bit on the next clock edge. Non-master lanes 0 to 9 map to flag bits 0, 1, 2, 3, 4, 5, 6, 10, 11, 12. Master lanes 0 to 4 map to flag bits 0, 1, 2, 3, 3. The non-master flags are at word 0h and the master flags at word 20h.
- R3: A lane's address is captured only on an edge where its flag was 0 before the edge, and it is then kept until a later capture. The non-master lane 0..9 captures are at words 8h, Ah, Ch, Eh, 10h, 12h, 14h, 1Ch, 3Ch, 3Eh. The master lane 0..4 captures are at words 28h, 2Ah, 2Ch, 2Eh, 30h.
- R4: Writing 1s to a set alias (non-master 2h, master 22h) while unlocked sets those flags, and raises the group interrupt when they are enabled. Writing 0 bits has no effect, a software set captures no address, and the alias reads 0.
- R5: Writing 1s to a clear alias (non-master 4h, master 24h) while unlocked clears those flags. Writing 0 bits has no effect, and the alias reads 0.
- R6: While unlock is low, writes to the set alias, the clear alias and the enable register are ignored.
- R7: The enable registers (non-master 6h, master 26h) are readable and writable. Bits that belong to no source read 0.
- R8: Each group interrupt is high exactly while at least one flag of that group is set together with its enable bit.
- R9: If a hardware violation and a software clear reach the same flag in one cycle, the flag ends up set.
- R10: Master lanes 3 and 4 share flag bit 3. When both pulse on the same edge, each records its own address.
- R11: Writes to the flag and capture registers are ignored. Odd word addresses and unlisted addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 7 | Register address in 16-bit words |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busUnlock | input | 1 | Protection unlock; gates set, clear and enable writes |
| busRdata | output | 32 | Combinational read data for busAddr |
| nmViol | input | 10 | Non-master violation pulses, one per lane |
| nmViolAddr | input | 320 | Violating address per non-master lane, lane n at bits 32n+31:32n |
| mViol | input | 5 | Master violation pulses, one per lane |
| mViolAddr | input | 160 | Violating address per master lane |
| nmIrq | output | 1 | Non-master group interrupt |
| mIrq | output | 1 | Master group interrupt |

## Verification
The hardest case to reach is a collision on one flag within one cycle. This covers a hardware pulse arriving together with a software clear, and both master host-write lanes firing together. Either collision must leave the flag set and keep the first captured address. Directed steps create each collision on purpose. The random phase also drives sparse pulses on every lane at the same time as random alias writes with a random unlock. This produces many accidental collisions, and a bench model checks the result of each one.

// File: rtl/avf_pkg.sv
package avf_pkg;
  localparam int ADDR_W   = 32;
  localparam int REG_W    = 32;
  localparam int BUS_AW   = 7;
  localparam int IDX_W    = BUS_AW - 1;
  localparam int POS_W    = 5;
  localparam int NM_NCAP  = 10;
  localparam int M_NCAP   = 5;

  // source bits present in each group's flag register
  localparam logic [REG_W-1:0] NM_VALID = 32'h0000_1C7F;
  localparam logic [REG_W-1:0] M_VALID  = 32'h0000_000F;

  // flag bit position per capture lane, lane 0 in the low field
  localparam logic [NM_NCAP*POS_W-1:0] NM_CAP_BIT =
    {5'd12, 5'd11, 5'd10, 5'd6, 5'd5, 5'd4, 5'd3, 5'd2, 5'd1, 5'd0};
  localparam logic [M_NCAP*POS_W-1:0] M_CAP_BIT =
    {5'd3, 5'd3, 5'd2, 5'd1, 5'd0};

  // register indices (word address / 2)
  localparam logic [IDX_W-1:0] NM_FLAG = 6'h00;
  localparam logic [IDX_W-1:0] NM_SET  = 6'h01;
  localparam logic [IDX_W-1:0] NM_CLR  = 6'h02;
  localparam logic [IDX_W-1:0] NM_EN   = 6'h03;
  localparam logic [IDX_W-1:0] M_FLAG  = 6'h10;
  localparam logic [IDX_W-1:0] M_SET   = 6'h11;
  localparam logic [IDX_W-1:0] M_CLR   = 6'h12;
  localparam logic [IDX_W-1:0] M_EN    = 6'h13;

  typedef struct packed {
    logic [REG_W-1:0] setMask;
    logic [REG_W-1:0] clrMask;
    logic             enWr;
    logic [REG_W-1:0] enData;
  } grpStb_t;

  function automatic logic [IDX_W-1:0] nmCapIdx(input int lane);
    logic [IDX_W-1:0] r;
    if (lane < 7)       r = IDX_W'(4 + lane);
    else if (lane == 7) r = 6'h0E;
    else if (lane == 8) r = 6'h1E;
    else                r = 6'h1F;
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] mCapIdx(input int lane);
    return IDX_W'(20 + lane);
  endfunction
endpackage

// File: rtl/avf_ctrl.sv
module avf_ctrl
  import avf_pkg::*;
(
  input  logic [BUS_AW-1:0]         busAddr,
  input  logic                      busWr,
  input  logic [REG_W-1:0]          busWdata,
  input  logic                      busUnlock,
  input  logic [REG_W-1:0]          nmFlags,
  input  logic [REG_W-1:0]          nmEn,
  input  logic [NM_NCAP*ADDR_W-1:0] nmCaps,
  input  logic [REG_W-1:0]          mFlags,
  input  logic [REG_W-1:0]          mEn,
  input  logic [M_NCAP*ADDR_W-1:0]  mCaps,
  output grpStb_t                   nmStb,
  output grpStb_t                   mStb,
  output logic [REG_W-1:0]          busRdata
);
  logic [IDX_W-1:0] regIdx;
  logic             evenAddr;
  logic             wrOk;

  assign regIdx   = busAddr[BUS_AW-1:1];
  assign evenAddr = ~busAddr[0];
  assign wrOk     = busWr & busUnlock & evenAddr;

  always_comb begin
    nmStb.setMask = (wrOk && regIdx == NM_SET) ? busWdata : '0;
    nmStb.clrMask = (wrOk && regIdx == NM_CLR) ? busWdata : '0;
    nmStb.enWr    = wrOk && regIdx == NM_EN;
    nmStb.enData  = busWdata;
    mStb.setMask  = (wrOk && regIdx == M_SET) ? busWdata : '0;
    mStb.clrMask  = (wrOk && regIdx == M_CLR) ? busWdata : '0;
    mStb.enWr     = wrOk && regIdx == M_EN;
    mStb.enData   = busWdata;
  end

  always_comb begin
    busRdata = '0;
    if (evenAddr) begin
      case (regIdx)
        NM_FLAG: busRdata = nmFlags;
        NM_EN:   busRdata = nmEn;
        M_FLAG:  busRdata = mFlags;
        M_EN:    busRdata = mEn;
        default: busRdata = '0;
      endcase
      for (int i = 0; i < NM_NCAP; i++)
        if (regIdx == nmCapIdx(i)) busRdata = nmCaps[i*ADDR_W +: ADDR_W];
      for (int i = 0; i < M_NCAP; i++)
        if (regIdx == mCapIdx(i)) busRdata = mCaps[i*ADDR_W +: ADDR_W];
    end
  end
endmodule

// File: rtl/avf_group_dp.sv
module avf_group_dp
  import avf_pkg::*;
#(
  parameter int                      NCAP    = 4,
  parameter logic [REG_W-1:0]        VALID   = 32'h0000_000F,
  parameter logic [NCAP*POS_W-1:0]   CAP_BIT = '0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  grpStb_t                 stb,
  input  logic [NCAP-1:0]         viol,
  input  logic [NCAP*ADDR_W-1:0]  violAddr,
  output logic [REG_W-1:0]        flags,
  output logic [REG_W-1:0]        en,
  output logic [NCAP*ADDR_W-1:0]  caps,
  output logic                    irq
);
  logic [REG_W-1:0] flagQ, enQ, hwSet, flagNext;

  always_comb begin
    hwSet = '0;
    for (int c = 0; c < NCAP; c++)
      if (viol[c]) hwSet[CAP_BIT[c*POS_W +: POS_W]] = 1'b1;
  end

  // hardware set is applied after the clear so it wins a collision
  assign flagNext = ((flagQ & ~stb.clrMask) | stb.setMask | hwSet) & VALID;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
      enQ   <= '0;
    end else begin
      flagQ <= flagNext;
      if (stb.enWr) enQ <= stb.enData & VALID;
    end
  end

  for (genvar c = 0; c < NCAP; c++) begin : g_cap
    localparam int POS = int'(CAP_BIT[c*POS_W +: POS_W]);
    logic [ADDR_W-1:0] capQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                     capQ <= '0;
      else if (viol[c] && !flagQ[POS]) capQ <= violAddr[c*ADDR_W +: ADDR_W];
    end
    assign caps[c*ADDR_W +: ADDR_W] = capQ;
  end

  assign flags = flagQ;
  assign en    = enQ;
  assign irq   = |(flagQ & enQ);
endmodule

// File: rtl/avf_capture_unit.sv
module avf_capture_unit
  import avf_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [BUS_AW-1:0]         busAddr,
  input  logic                      busWr,
  input  logic [REG_W-1:0]          busWdata,
  input  logic                      busUnlock,
  output logic [REG_W-1:0]          busRdata,
  input  logic [NM_NCAP-1:0]        nmViol,
  input  logic [NM_NCAP*ADDR_W-1:0] nmViolAddr,
  input  logic [M_NCAP-1:0]         mViol,
  input  logic [M_NCAP*ADDR_W-1:0]  mViolAddr,
  output logic                      nmIrq,
  output logic                      mIrq
);
  grpStb_t                   nmStb, mStb;
  logic [REG_W-1:0]          nmFlags, nmEn, mFlags, mEn;
  logic [NM_NCAP*ADDR_W-1:0] nmCaps;
  logic [M_NCAP*ADDR_W-1:0]  mCaps;

  avf_ctrl u_ctrl (
    .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata), .busUnlock(busUnlock),
    .nmFlags(nmFlags), .nmEn(nmEn), .nmCaps(nmCaps),
    .mFlags(mFlags), .mEn(mEn), .mCaps(mCaps),
    .nmStb(nmStb), .mStb(mStb), .busRdata(busRdata)
  );

  avf_group_dp #(.NCAP(NM_NCAP), .VALID(NM_VALID), .CAP_BIT(NM_CAP_BIT)) u_nm (
    .clk(clk), .rstN(rstN), .stb(nmStb), .viol(nmViol), .violAddr(nmViolAddr),
    .flags(nmFlags), .en(nmEn), .caps(nmCaps), .irq(nmIrq)
  );

  avf_group_dp #(.NCAP(M_NCAP), .VALID(M_VALID), .CAP_BIT(M_CAP_BIT)) u_m (
    .clk(clk), .rstN(rstN), .stb(mStb), .viol(mViol), .violAddr(mViolAddr),
    .flags(mFlags), .en(mEn), .caps(mCaps), .irq(mIrq)
  );
endmodule

// File: rtl/avf_checker.sv
module avf_checker
  import avf_pkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic [BUS_AW-1:0]         busAddr,
  input logic                      busWr,
  input logic [REG_W-1:0]          busWdata,
  input logic                      busUnlock,
  input logic [REG_W-1:0]          busRdata,
  input logic [NM_NCAP-1:0]        nmViol,
  input logic [M_NCAP-1:0]         mViol,
  input logic [REG_W-1:0]          nmFlags,
  input logic [REG_W-1:0]          nmEn,
  input logic [REG_W-1:0]          mFlags,
  input logic [REG_W-1:0]          mEn,
  input logic [NM_NCAP*ADDR_W-1:0] nmCaps,
  input logic                      nmIrq,
  input logic                      mIrq
);
  // R6
  en_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busUnlock |=> ($stable(nmEn) && $stable(mEn)));

  // R9
  hw_win_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmViol[0] |=> nmFlags[0]);

  // R10
  hic_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    mViol[4] |=> mFlags[3]);

  // R5
  clr_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busUnlock && busAddr == 7'h04 && busWdata[1] && !nmViol[1]) |=> !nmFlags[1]);

  // R4
  alias_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 7'h02 || busAddr == 7'h04 || busAddr == 7'h22 || busAddr == 7'h24)
      |-> busRdata == '0);

  // R8
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((nmFlags == '0) |-> !nmIrq) and ((mEn == '0) |-> !mIrq));

  // R3
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmFlags[0] |=> $stable(nmCaps[ADDR_W-1:0]));
endmodule

bind avf_capture_unit avf_checker u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
  .busUnlock(busUnlock), .busRdata(busRdata), .nmViol(nmViol), .mViol(mViol),
  .nmFlags(nmFlags), .nmEn(nmEn), .mFlags(mFlags), .mEn(mEn), .nmCaps(nmCaps),
  .nmIrq(nmIrq), .mIrq(mIrq)
);

// File: tb/avf_capture_unit_tb.sv
module avf_capture_unit_tb;
  import avf_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [6:0]   busAddr = '0;
  logic         busWr = 1'b0;
  logic [31:0]  busWdata = '0;
  logic         busUnlock = 1'b0;
  logic [31:0]  busRdata;
  logic [9:0]   nmViol = '0;
  logic [319:0] nmViolAddr = '0;
  logic [4:0]   mViol = '0;
  logic [159:0] mViolAddr = '0;
  logic         nmIrq, mIrq;

  avf_capture_unit u_dut (.*);

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;

  // bench model, built from the requirement text
  int nmBit[10] = '{0, 1, 2, 3, 4, 5, 6, 10, 11, 12};
  int mBit[5]   = '{0, 1, 2, 3, 3};
  int nmIdx[10] = '{4, 5, 6, 7, 8, 9, 10, 14, 30, 31};
  int mIdx[5]   = '{20, 21, 22, 23, 24};
  logic [31:0] eNmF = '0, eNmE = '0, eMF = '0, eME = '0;
  logic [31:0] eNmCap[10];
  logic [31:0] eMCap[5];

  function automatic logic [31:0] expRead(input logic [6:0] a);
    logic [31:0] r;
    int ix;
    r = '0;
    ix = int'(a[6:1]);
    if (!a[0]) begin
      if (ix == 0) r = eNmF;
      if (ix == 3) r = eNmE;
      if (ix == 16) r = eMF;
      if (ix == 19) r = eME;
      for (int i = 0; i < 10; i++) if (ix == nmIdx[i]) r = eNmCap[i];
      for (int i = 0; i < 5; i++)  if (ix == mIdx[i])  r = eMCap[i];
    end
    return r;
  endfunction

  function automatic void modelEdge();
    logic [31:0] nmS, nmC, mS, mC, nmH, mH;
    bit ok;
    ok = busWr && busUnlock && !busAddr[0];
    nmS = (ok && busAddr == 7'h02) ? busWdata : '0;
    nmC = (ok && busAddr == 7'h04) ? busWdata : '0;
    mS  = (ok && busAddr == 7'h22) ? busWdata : '0;
    mC  = (ok && busAddr == 7'h24) ? busWdata : '0;
    nmH = '0;
    mH = '0;
    for (int c = 0; c < 10; c++) if (nmViol[c]) begin
      nmH[nmBit[c]] = 1'b1;
      if (!eNmF[nmBit[c]]) eNmCap[c] = nmViolAddr[c*32 +: 32];
    end
    for (int c = 0; c < 5; c++) if (mViol[c]) begin
      mH[mBit[c]] = 1'b1;
      if (!eMF[mBit[c]]) eMCap[c] = mViolAddr[c*32 +: 32];
    end
    eNmF = ((eNmF & ~nmC) | nmS | nmH) & 32'h0000_1C7F;
    eMF  = ((eMF & ~mC) | mS | mH) & 32'h0000_000F;
    if (ok && busAddr == 7'h06) eNmE = busWdata & 32'h0000_1C7F;
    if (ok && busAddr == 7'h26) eME  = busWdata & 32'h0000_000F;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // apply the driven inputs for one edge, then idle them
  task automatic step();
    modelEdge();
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0;
    nmViol = '0;
    mViol = '0;
  endtask

  task automatic regWrite(input logic [6:0] a, input logic [31:0] d, input logic unl);
    busAddr = a;
    busWdata = d;
    busWr = 1'b1;
    busUnlock = unl;
    step();
  endtask

  task automatic readChk(input logic [6:0] a, input logic [31:0] exp, input string tag);
    busAddr = a;
    #1;
    check(busRdata, exp, tag);
  endtask

  task automatic checkIrq(input string tag);
    check({31'd0, nmIrq}, {31'd0, |(eNmF & eNmE)}, tag);
    check({31'd0, mIrq}, {31'd0, |(eMF & eME)}, tag);
  endtask

  // idle sweep over the whole address space, one address per cycle
  task automatic sweep(input string tag);
    checkIrq(tag);
    for (int a = 0; a < 128; a++) begin
      readChk(7'(a), expRead(7'(a)), tag);
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 10; i++) eNmCap[i] = '0;
    for (int i = 0; i < 5; i++) eMCap[i] = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check({30'd0, nmIrq, mIrq}, 32'd0, "R1 irq");
    sweep("R1 sweep");

    // R2 hardware pulse on non-master lane 2 (bit 2)
    nmViol[2] = 1'b1;
    nmViolAddr[2*32 +: 32] = 32'h1111_2222;
    step();
    readChk(7'h00, 32'h0000_0004, "R2 flag");
    readChk(7'h0C, 32'h1111_2222, "R3 capture");

    // R3 second pulse while flag set keeps first address
    nmViol[2] = 1'b1;
    nmViolAddr[2*32 +: 32] = 32'hDEAD_BEEF;
    step();
    readChk(7'h0C, 32'h1111_2222, "R3 hold");

    // R7 enable write masks reserved bits, R8 irq follows
    regWrite(7'h06, 32'hFFFF_FFFF, 1'b1);
    readChk(7'h06, 32'h0000_1C7F, "R7 enable");
    check({31'd0, nmIrq}, 32'd1, "R8 irq high");

    // R6 locked clear ignored
    regWrite(7'h04, 32'h0000_0004, 1'b0);
    readChk(7'h00, 32'h0000_0004, "R6 locked clear");
    regWrite(7'h06, 32'h0, 1'b0);
    readChk(7'h06, 32'h0000_1C7F, "R6 locked enable");

    // R5 clear, capture kept after clear
    regWrite(7'h04, 32'h0000_0004, 1'b1);
    readChk(7'h00, 32'h0, "R5 cleared");
    readChk(7'h04, 32'h0, "R5 alias reads 0");
    check({31'd0, nmIrq}, 32'd0, "R8 irq low");
    readChk(7'h0C, 32'h1111_2222, "R3 kept after clear");

    // R4 software set of bits 0 and 10
    regWrite(7'h02, 32'h0000_0401, 1'b1);
    readChk(7'h00, 32'h0000_0401, "R4 set");
    readChk(7'h02, 32'h0, "R4 alias reads 0");
    readChk(7'h08, 32'h0, "R4 no capture");
    check({31'd0, nmIrq}, 32'd1, "R4 irq");

    // R9 clear of bit 0 collides with lane 0 pulse
    nmViol[0] = 1'b1;
    nmViolAddr[31:0] = 32'h0000_0055;
    regWrite(7'h04, 32'h0000_0001, 1'b1);
    readChk(7'h00, 32'h0000_0401, "R9 set wins");
    readChk(7'h08, 32'h0, "R9 no capture");

    // R10 both host-write master lanes together
    mViol[3] = 1'b1;
    mViol[4] = 1'b1;
    mViolAddr[3*32 +: 32] = 32'hAAAA_0001;
    mViolAddr[4*32 +: 32] = 32'hBBBB_0002;
    step();
    readChk(7'h20, 32'h0000_0008, "R10 flag");
    readChk(7'h2E, 32'hAAAA_0001, "R10 lane3");
    readChk(7'h30, 32'hBBBB_0002, "R10 lane4");
    check({31'd0, mIrq}, 32'd0, "R8 master disabled");
    regWrite(7'h26, 32'h0000_0008, 1'b1);
    check({31'd0, mIrq}, 32'd1, "R8 master enabled");

    // R11 read-only and unmapped addresses
    regWrite(7'h00, 32'hFFFF_FFFF, 1'b1);
    readChk(7'h00, 32'h0000_0401, "R11 flags read-only");
    regWrite(7'h2E, 32'h0, 1'b1);
    readChk(7'h2E, 32'hAAAA_0001, "R11 capture read-only");
    readChk(7'h1A, 32'h0, "R11 unmapped");
    readChk(7'h01, 32'h0, "R11 odd");
    regWrite(7'h03, 32'h0000_0004, 1'b1);
    readChk(7'h00, 32'h0000_0401, "R11 odd write ignored");
    sweep("R1 R11 sweep after directed");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int pick;
      logic [6:0] wa [8] = '{7'h02, 7'h04, 7'h06, 7'h22, 7'h24, 7'h26, 7'h00, 7'h2C};
      for (int c = 0; c < 10; c++) begin
        nmViol[c] = ($urandom % 10) == 0;
        nmViolAddr[c*32 +: 32] = $urandom;
      end
      for (int c = 0; c < 5; c++) begin
        mViol[c] = ($urandom % 8) == 0;
        mViolAddr[c*32 +: 32] = $urandom;
      end
      pick = int'($urandom % 8);
      busWr = ($urandom % 2) == 0;
      busAddr = wa[pick];
      busWdata = $urandom;
      busUnlock = ($urandom % 4) != 0;
      step();
      checkIrq("R8 R9 random irq");
      readChk(7'h00, expRead(7'h00), "R2 R5 random nm flags");
      readChk(7'h20, expRead(7'h20), "R4 R10 random m flags");
      pick = int'($urandom % 64);
      readChk(7'(pick * 2), expRead(7'(pick * 2)), "R3 R6 random read");
      if (n % 500 == 499) sweep("R3 R7 random sweep");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule